// File: doc/BRIEF.md
# Audio Destination-Source Routing Matrix

This block is a crosspoint router for sample-based audio. Every audio destination holds exactly one source selection, while a single source may drive any number of destinations at once. Endpoints are named by a split identifier: a 3-bit group and a 5-bit channel. The group sits at bits [10:8] of the full identifier and the channel at bits [4:0]. Software sees the identifier as two halves, a high half (the group) and a low half (the channel).

Control arrives as plain register writes and reads on a four-slot staging port. To change a route, software writes the destination group, then the destination channel, then the source group, and last the source channel. The last of these writes commits the new entry to the routing table. To read a route back, software writes the two destination halves and then reads the two source halves. The full source identifier is rebuilt as (high << 8) | low.

Audio samples enter as one flat vector with a slot for each possible source. A registered flat vector leaves with a slot for each destination. All destination slots are reloaded together on a frame strobe, so a route change never tears a sample.

Top module: `audio_route_matrix`

## Requirements
- R1: After reset every table entry selects source 0, every destination output slot is zero, rd_valid is low, and a route query of any destination returns 0.
- R2: Register addresses are 0 = destination group, 1 = destination channel, 2 = source group and 3 = source channel. Writes to addresses 0, 1 and 2 only stage a value; they change neither the table nor the outputs.
- R3: A write to address 3 commits source index {staged source group, written channel} to destination index {staged destination group, staged destination channel}. It does so only when the two group fields are below 8 and the two channel fields are below 32.
- R4: A commit whose staged or written field breaks those limits (a group of 8 or more, or a channel of 32 or more) leaves the whole table unchanged.
- R5: A read on reg_rd gives rd_valid high with rd_data on the next cycle. Address 0 or 1 returns the staged destination half. Address 2 returns the group and address 3 the channel of the staged destination's current source. Addresses 2 and 3 return 0 when the staged destination is out of range.
- R6: Any number of destinations may select the same source. A new commit to a destination replaces its previous selection.
- R7: On a clock edge with frame_strobe high, every destination slot loads the sample of its selected source, all in the same cycle. Without frame_strobe the outputs hold even if src_samples change.
- R8: Source index 0 is silence: a destination routed to it outputs zero whatever src_samples slot 0 carries.
- R9: A commit made on the same edge as frame_strobe takes effect from the following frame; the frame captured on that edge uses the previous route.
- R10: Endpoint index k = group*32 + channel occupies bits [k*SAMPLE_W +: SAMPLE_W] of src_samples and dst_samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Staging register select |
| reg_wdata | input | REG_W (6) | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after reg_rd |
| rd_data | output | REG_W (6) | Read data |
| frame_strobe | input | 1 | Frame boundary; reloads all outputs |
| src_samples | input | 256*SAMPLE_W | Flat source sample vector |
| dst_samples | output | 256*SAMPLE_W | Flat registered destination sample vector |

## Verification
Routes are tried as a single point-to-point link, as a three-way fan-out from one source, as a reroute of a used destination, and as a route to the silence source. These cases separate a wrong index mapping from a missing fan-out, and both from a stale entry or a mishandled source 0. Commits with an oversize group or channel in each field position check that rejection is done field by field. Partial sequences that stop before the source-channel write check that staging alone changes nothing. Sample changes without a strobe, and a commit on the same edge as a strobe, check that outputs move only at frame boundaries and that the frame captured on that edge uses the old route.

// File: rtl/route_matrix_pkg.sv
package route_matrix_pkg;

  typedef enum logic [1:0] {
    RA_DST_GRP = 2'd0,
    RA_DST_CH  = 2'd1,
    RA_SRC_GRP = 2'd2,
    RA_SRC_CH  = 2'd3
  } route_reg_e;

  // True when no bit at or above position 'bits' is set.
  function automatic logic field_fits(input logic [31:0] v, input int unsigned bits);
    return (v >> bits) == 32'd0;
  endfunction

  // Compact table index from group and channel.
  function automatic int unsigned endpoint_index(input int unsigned grp, input int unsigned ch,
                                                 input int unsigned ch_w);
    return (grp << ch_w) | ch;
  endfunction

endpackage

// File: rtl/rm_stage.sv
module rm_stage
  import route_matrix_pkg::*;
#(
  parameter int GRP_W = 3,
  parameter int CH_W  = 5,
  parameter int REG_W = 6,
  localparam int IDX_W = GRP_W + CH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] dst_grp_q,
  output logic [REG_W-1:0] dst_ch_q,
  output logic             dst_ok,
  output logic [IDX_W-1:0] dst_idx,
  output logic             commit_fire,
  output logic             commit_reject,
  output logic [IDX_W-1:0] commit_src
);

  logic [REG_W-1:0] src_grp_q;
  logic             commit_try;
  logic             fields_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_grp_q <= '0;
      dst_ch_q  <= '0;
      src_grp_q <= '0;
    end else if (wr_en) begin
      case (route_reg_e'(wr_addr))
        RA_DST_GRP: dst_grp_q <= wr_data;
        RA_DST_CH:  dst_ch_q  <= wr_data;
        RA_SRC_GRP: src_grp_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    dst_ok    = field_fits(32'(dst_grp_q), GRP_W) && field_fits(32'(dst_ch_q), CH_W);
    fields_ok = dst_ok && field_fits(32'(src_grp_q), GRP_W) && field_fits(32'(wr_data), CH_W);
    dst_idx   = IDX_W'(endpoint_index(32'(dst_grp_q[GRP_W-1:0]), 32'(dst_ch_q[CH_W-1:0]), CH_W));
    commit_src = IDX_W'(endpoint_index(32'(src_grp_q[GRP_W-1:0]), 32'(wr_data[CH_W-1:0]), CH_W));
  end

  assign commit_try    = wr_en && (route_reg_e'(wr_addr) == RA_SRC_CH);
  assign commit_fire   = commit_try && fields_ok;
  assign commit_reject = commit_try && !fields_ok;

endmodule

// File: rtl/rm_table.sv
module rm_table #(
  parameter int IDX_W = 8,
  localparam int N = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [IDX_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [IDX_W-1:0] rdata,
  output logic [N*IDX_W-1:0] route_flat
);

  logic [IDX_W-1:0] entry [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) entry[i] <= '0;
    end else if (we) begin
      entry[waddr] <= wdata;
    end
  end

  assign rdata = entry[raddr];

  for (genvar d = 0; d < N; d++) begin : g_flat
    assign route_flat[d*IDX_W +: IDX_W] = entry[d];
  end

endmodule

// File: rtl/rm_xbar.sv
module rm_xbar #(
  parameter int IDX_W    = 8,
  parameter int SAMPLE_W = 8,
  localparam int N = 1 << IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_strobe,
  input  logic [N*IDX_W-1:0]    route_flat,
  input  logic [N*SAMPLE_W-1:0] src_flat,
  output logic [N*SAMPLE_W-1:0] dst_flat
);

  logic [SAMPLE_W-1:0] pick [N];

  for (genvar d = 0; d < N; d++) begin : g_pick
    logic [IDX_W-1:0] sel;
    assign sel = route_flat[d*IDX_W +: IDX_W];
    // Index 0 is the reserved silence source.
    assign pick[d] = (sel == '0) ? '0 : src_flat[sel*SAMPLE_W +: SAMPLE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_flat <= '0;
    end else if (frame_strobe) begin
      for (int d = 0; d < N; d++) dst_flat[d*SAMPLE_W +: SAMPLE_W] <= pick[d];
    end
  end

endmodule

// File: rtl/audio_route_matrix.sv
module audio_route_matrix
  import route_matrix_pkg::*;
#(
  parameter int GRP_W    = 3,
  parameter int CH_W     = 5,
  parameter int REG_W    = 6,
  parameter int SAMPLE_W = 8,
  localparam int IDX_W = GRP_W + CH_W,
  localparam int N     = 1 << IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [1:0]            reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic                  rd_valid,
  output logic [REG_W-1:0]      rd_data,
  input  logic                  frame_strobe,
  input  logic [N*SAMPLE_W-1:0] src_samples,
  output logic [N*SAMPLE_W-1:0] dst_samples
);

  logic [REG_W-1:0]   dst_grp_q;
  logic [REG_W-1:0]   dst_ch_q;
  logic               dst_ok;
  logic [IDX_W-1:0]   dst_idx;
  logic               commit_fire;
  logic               commit_reject;
  logic [IDX_W-1:0]   commit_src;
  logic [IDX_W-1:0]   cur_src;
  logic [N*IDX_W-1:0] route_flat;

  rm_stage #(.GRP_W(GRP_W), .CH_W(CH_W), .REG_W(REG_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .dst_grp_q(dst_grp_q), .dst_ch_q(dst_ch_q),
    .dst_ok(dst_ok), .dst_idx(dst_idx),
    .commit_fire(commit_fire), .commit_reject(commit_reject),
    .commit_src(commit_src)
  );

  rm_table #(.IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .we(commit_fire), .waddr(dst_idx), .wdata(commit_src),
    .raddr(dst_idx), .rdata(cur_src),
    .route_flat(route_flat)
  );

  rm_xbar #(.IDX_W(IDX_W), .SAMPLE_W(SAMPLE_W)) u_xbar (
    .clk(clk), .rst_n(rst_n),
    .frame_strobe(frame_strobe),
    .route_flat(route_flat),
    .src_flat(src_samples),
    .dst_flat(dst_samples)
  );

  // Registered readback of the staging port.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) begin
        case (route_reg_e'(reg_addr))
          RA_DST_GRP: rd_data <= dst_grp_q;
          RA_DST_CH:  rd_data <= dst_ch_q;
          RA_SRC_GRP: rd_data <= dst_ok ? REG_W'(cur_src[IDX_W-1:CH_W]) : '0;
          default:    rd_data <= dst_ok ? REG_W'(cur_src[CH_W-1:0]) : '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/audio_route_matrix_checker.sv
module audio_route_matrix_checker #(
  parameter int N        = 256,
  parameter int IDX_W    = 8,
  parameter int SAMPLE_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic                  reg_rd,
  input logic [1:0]            reg_addr,
  input logic                  frame_strobe,
  input logic                  rd_valid,
  input logic [N*SAMPLE_W-1:0] dst_samples,
  input logic [N*IDX_W-1:0]    route_flat,
  input logic                  commit_fire,
  input logic                  commit_reject
);

  // R2: the table moves only on an accepted commit.
  p_table_only_on_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_fire |=> $stable(route_flat));

  // R3: an accepted commit comes only from a source-channel write.
  p_commit_on_src_ch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> (reg_wr && reg_addr == 2'd3));

  // R4: a rejected commit leaves every entry as it was.
  p_reject_keeps_table_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_reject |=> $stable(route_flat));

  // R5: read data is valid exactly one cycle after a read strobe.
  p_rd_valid_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> rd_valid);

  p_no_spurious_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !rd_valid);

  // R7: outputs hold between frame boundaries.
  p_hold_between_frames_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |=> $stable(dst_samples));

endmodule

bind audio_route_matrix audio_route_matrix_checker #(
  .N(N), .IDX_W(IDX_W), .SAMPLE_W(SAMPLE_W)
) u_checker (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .frame_strobe(frame_strobe), .rd_valid(rd_valid), .dst_samples(dst_samples),
  .route_flat(route_flat), .commit_fire(commit_fire), .commit_reject(commit_reject)
);

// File: tb/audio_route_matrix_bench.sv
`timescale 1ns/1ps
module audio_route_matrix_bench;
  localparam int REG_W = 6;
  localparam int SW    = 8;
  localparam int N     = 256;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]        reg_addr = '0;
  logic [REG_W-1:0]  reg_wdata = '0;
  logic              rd_valid;
  logic [REG_W-1:0]  rd_data;
  logic              frame_strobe = 1'b0;
  logic [N*SW-1:0]   src_samples;
  logic [N*SW-1:0]   dst_samples;
  logic [SW-1:0]     src_v [N];

  int checks = 0, errors = 0;
  bit started = 0;

  audio_route_matrix u_audio_route_matrix (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .frame_strobe(frame_strobe), .src_samples(src_samples), .dst_samples(dst_samples)
  );

  always_comb for (int k = 0; k < N; k++) src_samples[k*SW +: SW] = src_v[k];

  function automatic logic [SW-1:0] pat(input int k, input int seed);
    return SW'((k * 37 + seed * 11 + 5) & 255);
  endfunction

  function automatic logic [SW-1:0] slot(input int d);
    return dst_samples[d*SW +: SW];
  endfunction

  // Behavioural reference model (R10 slot numbering: group*32+channel).
  int m_tab [N];
  logic [SW-1:0] m_out [N];
  int m_dg, m_dc, m_sg, m_rd;
  bit m_rv;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_tab[i] = 0; m_out[i] = '0; end
      m_dg = 0; m_dc = 0; m_sg = 0; m_rd = 0; m_rv = 0;
    end else begin
      m_rv = reg_rd;
      if (reg_rd) begin
        case (reg_addr)
          2'd0: m_rd = m_dg;
          2'd1: m_rd = m_dc;
          2'd2: m_rd = (m_dg < 8 && m_dc < 32) ? m_tab[m_dg*32 + m_dc] / 32 : 0;
          default: m_rd = (m_dg < 8 && m_dc < 32) ? m_tab[m_dg*32 + m_dc] % 32 : 0;
        endcase
      end
      if (frame_strobe)
        for (int d = 0; d < N; d++) m_out[d] = (m_tab[d] == 0) ? '0 : src_v[m_tab[d]];
      if (reg_wr) begin
        case (reg_addr)
          2'd0: m_dg = int'(reg_wdata);
          2'd1: m_dc = int'(reg_wdata);
          2'd2: m_sg = int'(reg_wdata);
          default:
            if (m_dg < 8 && m_dc < 32 && m_sg < 8 && reg_wdata < 32)
              m_tab[m_dg*32 + m_dc] = m_sg*32 + int'(reg_wdata);
        endcase
      end
    end
  end

  // Per-cycle comparison against the model (R7 outputs, R5 readback).
  always @(negedge clk) begin
    if (rst_n && started) begin
      int bad;
      bad = -1;
      for (int d = 0; d < N; d++) if (bad < 0 && slot(d) !== m_out[d]) bad = d;
      checks++;
      if (bad >= 0) begin
        errors++;
        $display("FAIL R7 cycle compare slot %0d: actual %0d expected %0d", bad, slot(bad), m_out[bad]);
      end
      checks++;
      if (rd_valid !== m_rv || (m_rv && int'(rd_data) != m_rd)) begin
        errors++;
        $display("FAIL R5 cycle compare: actual valid %0b data %0d expected valid %0b data %0d",
                 rd_valid, rd_data, m_rv, m_rd);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = REG_W'(v);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 2'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    v = int'(rd_data);
  endtask

  task automatic route(input int dg, input int dc, input int sg, input int sc);
    wr(0, dg); wr(1, dc); wr(2, sg); wr(3, sc);
  endtask

  task automatic query(input int dg, input int dc, output int id);
    int hi, lo;
    wr(0, dg); wr(1, dc);
    rd(2, hi); rd(3, lo);
    id = (hi << 8) | lo;
  endtask

  task automatic frame(input int seed);
    @(negedge clk);
    for (int k = 0; k < N; k++) src_v[k] = pat(k, seed);
    frame_strobe = 1'b1;
    @(negedge clk);
    frame_strobe = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired (all requirements): actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, nz;
    for (int k = 0; k < N; k++) src_v[k] = pat(k, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    started = 1;
    @(negedge clk);

    // R1 reset state
    nz = 0;
    for (int d = 0; d < N; d++) if (slot(d) != '0) nz++;
    chk("R1 nonzero outputs after reset", nz, 0);
    chk("R1 rd_valid after reset", rd_valid, 0);
    query(1, 3, v);
    chk("R1 route of (1,3) after reset", v, 0);
    frame(1);
    chk("R8 default silence with slot 0 live", slot(0), 0);

    // R3 / R10 single link
    route(1, 3, 2, 7);
    frame(2);
    chk("R3 R10 dst 35 from src 71", slot(35), pat(71, 2));
    query(1, 3, v);
    chk("R5 query (1,3)", v, 32'h207);

    // R6 fan-out
    route(0, 0, 5, 17); route(7, 31, 5, 17); route(3, 9, 5, 17);
    frame(3);
    chk("R6 fan-out dst 0", slot(0), pat(177, 3));
    chk("R6 fan-out dst 255", slot(255), pat(177, 3));
    chk("R6 fan-out dst 105", slot(105), pat(177, 3));
    chk("R6 other route kept", slot(35), pat(71, 3));

    // R6 reroute replaces
    route(1, 3, 0, 4);
    query(1, 3, v);
    chk("R6 reroute query", v, 32'h004);
    frame(4);
    chk("R6 reroute output", slot(35), pat(4, 4));

    // R4 rejection per field
    route(1, 3, 8, 2);
    query(1, 3, v);
    chk("R4 source group 8 rejected", v, 32'h004);
    route(1, 3, 1, 32);
    query(1, 3, v);
    chk("R4 source channel 32 rejected", v, 32'h004);
    route(9, 0, 1, 1);
    query(1, 0, v);
    chk("R4 destination group 9 rejected", v, 0);
    route(1, 33, 1, 1);
    query(1, 1, v);
    chk("R4 destination channel 33 rejected", v, 0);

    // R5 readback of staged values and of an invalid destination
    wr(0, 9); wr(1, 6);
    rd(0, v); chk("R5 staged destination group", v, 9);
    rd(1, v); chk("R5 staged destination channel", v, 6);
    rd(2, v); chk("R5 invalid destination reads zero", v, 0);

    // R2 staging alone does nothing
    wr(0, 1); wr(1, 3); wr(2, 6);
    query(1, 3, v);
    chk("R2 staging without commit", v, 32'h004);
    frame(5);
    chk("R2 output after staging only", slot(35), pat(4, 5));

    // R7 hold without strobe
    @(negedge clk);
    for (int k = 0; k < N; k++) src_v[k] = pat(k, 9);
    repeat (3) @(negedge clk);
    chk("R7 hold without frame strobe", slot(35), pat(4, 5));

    // R8 silence source
    route(1, 3, 0, 0);
    frame(6);
    chk("R8 routed to silence", slot(35), 0);

    // R9 commit on the frame edge
    wr(0, 2); wr(1, 2); wr(2, 4);
    @(negedge clk);
    for (int k = 0; k < N; k++) src_v[k] = pat(k, 7);
    reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = REG_W'(1); frame_strobe = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; frame_strobe = 1'b0;
    chk("R9 same-edge frame uses old route", slot(66), 0);
    frame(8);
    chk("R9 next frame uses new route", slot(66), pat(129, 8));

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule